// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle load/store RISC datapath, built as a small microprogrammed engine rather than as hand-written next-state logic. A 4-bit microaddress register selects one of sixteen 18-bit control words. Sixteen bits of the selected word go straight to the datapath as control signals. The remaining 2-bit sequencing field chooses where the microaddress goes next: back to the fetch word, one address forward, or a jump through one of two 64-entry tables indexed by the instruction opcode.

Ten microinstructions carry five instruction classes: loads, stores, register-register ALU operations, conditional branches and jumps. The outputs depend only on the current microaddress, so each microinstruction lasts exactly one clock. When a dispatch finds an opcode that its table does not list, the sequencer goes back to fetch and raises a flag for one cycle. The control store and both dispatch tables are fixed constants computed inside the block.

Top module: `ucode_sequencer`

## Requirements
- R1: While rst_ni is low, uaddr_o is 0, bad_op_o is 0 and ctrl_o carries the fetch word 16'h08A2. Reset acts asynchronously.
- R2: ctrl_o bit fields are [15:14] ALU op, [13] ALU source A, [12:11] ALU source B, [10] register write, [9] destination select, [8] memory-to-register, [7] memory read, [6] address select, [5] instruction-register write, [4] memory write, [3:2] PC source, [1] PC write, [0] conditional PC write. ctrl_o depends only on uaddr_o. Address 0 gives 16'h08A2, 1 gives 16'h1800, 2 gives 16'h3000, 3 gives 16'h00C0, 4 gives 16'h0500, 5 gives 16'h0050, 6 gives 16'hA000, 7 gives 16'h0600, 8 gives 16'h6005 and 9 gives 16'h000A.
- R3: From microaddresses 0, 3 and 6, the next microaddress is the current one plus 1.
- R4: From microaddress 1, the next microaddress comes from the first dispatch table on opcode_i. Opcode 6'b100011 gives 2, 6'b101011 gives 2, 6'b000000 gives 6, 6'b000100 gives 8 and 6'b000010 gives 9.
- R5: From microaddress 2, the next microaddress comes from the second dispatch table on the opcode present in that cycle. Opcode 6'b100011 gives 3 and 6'b101011 gives 5.
- R6: From microaddresses 4, 5, 7, 8 and 9, the next microaddress is 0.
- R7: A dispatch on an opcode that its table does not list sends the microaddress to 0. bad_op_o is 1 for exactly the one cycle in which uaddr_o is 0 after that dispatch, and 0 at all other times.
- R8: opcode_i has no effect on the sequence, or on bad_op_o, while the microaddress is 0, 3 or 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | OPCODE_W (6) | Opcode field from the instruction register |
| ctrl_o | output | CTRL_W (16) | Datapath control signals |
| uaddr_o | output | UADDR_W (4) | Current microaddress |
| bad_op_o | output | 1 | One-cycle flag for an unlisted opcode at a dispatch |

## Verification
The bench builds the block with its default widths: a 4-bit microaddress, a 6-bit opcode and 16 control bits. With a 6-bit opcode, all 64 codes can be swept through the first dispatch, so every unlisted code is tested as well as the five listed ones. With a 4-bit microaddress, every reachable word of the store can be compared against its expected value along complete paths. Directed cases change the opcode while the second dispatch is pending and during the steps that ignore it, and assert reset in the middle of a path.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int SEQ_W = 2;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_e;

  // Control word: {alu_op[1:0], src_a, src_b[1:0], reg_wr, reg_dst, mem_to_reg,
  //                mem_rd, i_or_d, ir_wr, mem_wr, pc_src[1:0], pc_wr, pc_wr_cond}
  typedef struct packed {
    logic [1:0] alu_op;
    logic       src_a;
    logic [1:0] src_b;
    logic       reg_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       mem_rd;
    logic       i_or_d;
    logic       ir_wr;
    logic       mem_wr;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       pc_wr_cond;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);
  localparam int WORD_BITS = CTRL_BITS + SEQ_W;

  function automatic logic [WORD_BITS-1:0] store_word(input int a);
    ctrl_t c;
    seq_e  s;
    c = '0;
    s = SEQ_FETCH;
    case (a)
      0: begin c.src_b = 2'b01; c.mem_rd = 1'b1; c.ir_wr = 1'b1; c.pc_wr = 1'b1; s = SEQ_NEXT; end
      1: begin c.src_b = 2'b11; s = SEQ_DISP1; end
      2: begin c.src_a = 1'b1; c.src_b = 2'b10; s = SEQ_DISP2; end
      3: begin c.mem_rd = 1'b1; c.i_or_d = 1'b1; s = SEQ_NEXT; end
      4: begin c.reg_wr = 1'b1; c.mem_to_reg = 1'b1; end
      5: begin c.mem_wr = 1'b1; c.i_or_d = 1'b1; end
      6: begin c.alu_op = 2'b10; c.src_a = 1'b1; s = SEQ_NEXT; end
      7: begin c.reg_wr = 1'b1; c.reg_dst = 1'b1; end
      8: begin c.alu_op = 2'b01; c.src_a = 1'b1; c.pc_src = 2'b01; c.pc_wr_cond = 1'b1; end
      9: begin c.pc_src = 2'b10; c.pc_wr = 1'b1; end
      default: ; // unused words: no control, back to fetch
    endcase
    return {c, s};
  endfunction

  // Returns {hit, target}
  function automatic logic [4:0] disp_entry(input int tbl, input int op);
    logic [4:0] r;
    r = '0;
    if (tbl == 1) begin
      case (op)
        'b100011: r = {1'b1, 4'd2};
        'b101011: r = {1'b1, 4'd2};
        'b000000: r = {1'b1, 4'd6};
        'b000100: r = {1'b1, 4'd8};
        'b000010: r = {1'b1, 4'd9};
        default:  r = '0;
      endcase
    end else begin
      case (op)
        'b100011: r = {1'b1, 4'd3};
        'b101011: r = {1'b1, 4'd5};
        default:  r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output seq_e              seq_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = CTRL_W + SEQ_W;

  logic [WORD_W-1:0] rom [DEPTH];
  logic [WORD_W-1:0] word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = WORD_W'(store_word(i));
  end

  assign word   = rom[addr_i];
  assign ctrl_o = word[WORD_W-1:SEQ_W];
  assign seq_o  = seq_e'(word[SEQ_W-1:0]);
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OP_W     = 6,
  parameter int ADDR_W   = 4,
  parameter int TABLE_ID = 1
) (
  input  logic [OP_W-1:0]   op_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              hit_o
);
  localparam int ENTRIES = 1 << OP_W;
  localparam int ENT_W   = ADDR_W + 1;

  logic [ENT_W-1:0] tbl [ENTRIES];
  logic [ENT_W-1:0] ent;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign tbl[i] = ENT_W'(disp_entry(TABLE_ID, i));
  end

  assign ent   = tbl[op_i];
  assign hit_o = ent[ADDR_W];
  assign tgt_o = ent[ADDR_W-1:0];
endmodule

// File: rtl/ucode_next_sel.sv
module ucode_next_sel
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]      uaddr_i,
  input  seq_e                   seq_i,
  input  logic [1:0]             hit_i,
  input  logic [1:0][ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0]      nxt_o,
  output logic                   illegal_o
);
  always_comb begin
    nxt_o     = '0;
    illegal_o = 1'b0;
    case (seq_i)
      SEQ_NEXT:  nxt_o = uaddr_i + 1'b1;
      SEQ_DISP1: begin
        nxt_o     = hit_i[0] ? tgt_i[0] : '0;
        illegal_o = ~hit_i[0];
      end
      SEQ_DISP2: begin
        nxt_o     = hit_i[1] ? tgt_i[1] : '0;
        illegal_o = ~hit_i[1];
      end
      default:   nxt_o = '0;
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int UADDR_W  = 4,
  parameter int OPCODE_W = 6,
  parameter int CTRL_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OPCODE_W-1:0] opcode_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [UADDR_W-1:0]  uaddr_o,
  output logic                bad_op_o
);
  logic [UADDR_W-1:0]      uaddr_q, uaddr_d;
  logic                    bad_q, bad_d;
  seq_e                    seq;
  logic [1:0]              hit;
  logic [1:0][UADDR_W-1:0] tgt;

  ucode_store #(.ADDR_W(UADDR_W), .CTRL_W(CTRL_W)) u_store (
    .addr_i (uaddr_q),
    .ctrl_o (ctrl_o),
    .seq_o  (seq)
  );

  for (genvar t = 0; t < 2; t++) begin : g_disp
    ucode_dispatch #(.OP_W(OPCODE_W), .ADDR_W(UADDR_W), .TABLE_ID(t + 1)) u_disp (
      .op_i  (opcode_i),
      .tgt_o (tgt[t]),
      .hit_o (hit[t])
    );
  end

  ucode_next_sel #(.ADDR_W(UADDR_W)) u_next (
    .uaddr_i   (uaddr_q),
    .seq_i     (seq),
    .hit_i     (hit),
    .tgt_i     (tgt),
    .nxt_o     (uaddr_d),
    .illegal_o (bad_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uaddr_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      uaddr_q <= uaddr_d;
      bad_q   <= bad_d;
    end
  end

  assign uaddr_o  = uaddr_q;
  assign bad_op_o = bad_q;
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk #(
  parameter int UADDR_W  = 4,
  parameter int OPCODE_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [OPCODE_W-1:0] opcode_i,
  input logic [UADDR_W-1:0]  uaddr_o,
  input logic                bad_op_o
);
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_o == 4'd0 || uaddr_o == 4'd3 || uaddr_o == 4'd6) |=> uaddr_o == $past(uaddr_o) + 4'd1);

  a_r4_disp1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_o == 4'd1) |=> (uaddr_o inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9}));

  a_r4_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_o == 4'd1 && opcode_i == 6'b000100) |=> uaddr_o == 4'd8);

  a_r5_disp2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_o == 4'd2) |=> (uaddr_o inside {4'd0, 4'd3, 4'd5}));

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_o inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd9}) |=> uaddr_o == 4'd0);

  a_r7_flag_at_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |-> uaddr_o == 4'd0);

  a_r7_flag_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |=> !bad_op_o);

  a_r8_no_flag_off_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uaddr_o == 4'd1 || uaddr_o == 4'd2) |=> !bad_op_o);
endmodule

bind ucode_sequencer ucode_sequencer_chk #(.UADDR_W(UADDR_W), .OPCODE_W(OPCODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opcode_i (opcode_i),
  .uaddr_o  (uaddr_o),
  .bad_op_o (bad_op_o)
);

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;
  localparam int MAX_CYC = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [15:0] ctrl_o;
  logic [3:0]  uaddr_o;
  logic        bad_op_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ucode_sequencer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i),
    .ctrl_o(ctrl_o), .uaddr_o(uaddr_o), .bad_op_o(bad_op_o)
  );

  // {opcode, length, path nibbles (step 0 in lsb), flag expected}
  localparam int NV = 7;
  localparam logic [30:0] VEC [NV] = '{
    {6'b100011, 4'd5, 20'h43210, 1'b0},
    {6'b101011, 4'd4, 20'h05210, 1'b0},
    {6'b000000, 4'd4, 20'h07610, 1'b0},
    {6'b000100, 4'd3, 20'h00810, 1'b0},
    {6'b000010, 4'd3, 20'h00910, 1'b0},
    {6'b111111, 4'd2, 20'h00010, 1'b1},
    {6'b001000, 4'd2, 20'h00010, 1'b1}
  };

  function automatic logic [15:0] exp_word(input logic [3:0] a);
    case (a)
      4'd0: return 16'h08A2;  4'd1: return 16'h1800;
      4'd2: return 16'h3000;  4'd3: return 16'h00C0;
      4'd4: return 16'h0500;  4'd5: return 16'h0050;
      4'd6: return 16'hA000;  4'd7: return 16'h0600;
      4'd8: return 16'h6005;  4'd9: return 16'h000A;
      default: return 16'h0000;
    endcase
  endfunction

  // {listed, target} for the first dispatch
  function automatic logic [4:0] exp_d1(input logic [5:0] op);
    case (op)
      6'b100011, 6'b101011: return {1'b1, 4'd2};
      6'b000000:            return {1'b1, 4'd6};
      6'b000100:            return {1'b1, 4'd8};
      6'b000010:            return {1'b1, 4'd9};
      default:              return {1'b0, 4'd0};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic to_fetch();
    for (int k = 0; k < 8 && uaddr_o != 4'd0; k++) @(negedge clk_i);
  endtask

  initial begin
    #(MAX_CYC * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1 uaddr in reset", 16'(uaddr_o), 16'h0);
    chk("R1 ctrl in reset", ctrl_o, 16'h08A2);
    chk("R1 flag in reset", 16'(bad_op_o), 16'h0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;

    // Path table: R2..R7
    for (int v = 0; v < NV; v++) begin
      logic [5:0]  op;
      logic [3:0]  len;
      logic [19:0] path;
      logic        bad;
      {op, len, path, bad} = VEC[v];
      opcode_i = op;
      for (int s = 0; s < int'(len); s++) begin
        logic [3:0] ea;
        logic [3:0] pa;
        ea = path[s*4 +: 4];
        if (s > 0) begin
          pa = path[(s-1)*4 +: 4];
          if (pa == 4'd1)      chk("R4 dispatch one", 16'(uaddr_o), 16'(ea));
          else if (pa == 4'd2) chk("R5 dispatch two", 16'(uaddr_o), 16'(ea));
          else                 chk("R3 advance", 16'(uaddr_o), 16'(ea));
          if (s == 1) chk("R7 flag clears", 16'(bad_op_o), 16'h0);
        end else begin
          chk("R3 path start", 16'(uaddr_o), 16'h0);
        end
        chk("R2 control word", ctrl_o, exp_word(ea));
        @(negedge clk_i);
      end
      if (bad) begin
        chk("R7 unlisted restarts", 16'(uaddr_o), 16'h0);
        chk("R7 flag raised", 16'(bad_op_o), 16'h1);
      end else begin
        chk("R6 return to fetch", 16'(uaddr_o), 16'h0);
        chk("R6 no flag", 16'(bad_op_o), 16'h0);
      end
    end

    // R4/R7: sweep every opcode through the first dispatch
    for (int o = 0; o < 64; o++) begin
      logic [4:0] e;
      to_fetch();
      opcode_i = 6'(o);
      e = exp_d1(6'(o));
      @(negedge clk_i);
      @(negedge clk_i);
      chk($sformatf("R4 sweep op %0d", o), 16'(uaddr_o), 16'(e[3:0]));
      chk($sformatf("R7 sweep flag op %0d", o), 16'(bad_op_o), 16'(!e[4]));
      @(negedge clk_i);
    end

    // R5: opcode changed to store while the second dispatch is pending
    to_fetch();
    @(negedge clk_i);
    opcode_i = 6'b100011;
    @(negedge clk_i);
    chk("R5 at address two", 16'(uaddr_o), 16'h2);
    opcode_i = 6'b101011;
    @(negedge clk_i);
    chk("R5 uses current opcode", 16'(uaddr_o), 16'h5);

    // R7: register opcode reaching the second dispatch
    to_fetch();
    opcode_i = 6'b100011;
    @(negedge clk_i); @(negedge clk_i);
    opcode_i = 6'b000000;
    @(negedge clk_i);
    chk("R7 second table miss", 16'(uaddr_o), 16'h0);
    chk("R7 second table flag", 16'(bad_op_o), 16'h1);

    // R8: opcode ignored at addresses 0, 3 and 6
    to_fetch();
    opcode_i = 6'b111111;
    @(negedge clk_i);
    chk("R8 garbage at fetch", 16'(uaddr_o), 16'h1);
    chk("R8 no flag after fetch", 16'(bad_op_o), 16'h0);
    opcode_i = 6'b000000;
    @(negedge clk_i);
    chk("R8 reach ALU step", 16'(uaddr_o), 16'h6);
    opcode_i = 6'b111111;
    @(negedge clk_i);
    chk("R8 garbage at ALU step", 16'(uaddr_o), 16'h7);
    @(negedge clk_i);
    chk("R8 no flag at return", 16'(bad_op_o), 16'h0);
    opcode_i = 6'b100011;
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 reach load address", 16'(uaddr_o), 16'h2);
    @(negedge clk_i);
    chk("R8 reach read step", 16'(uaddr_o), 16'h3);
    opcode_i = 6'b000100;
    @(negedge clk_i);
    chk("R8 garbage at read step", 16'(uaddr_o), 16'h4);
    chk("R2 register write word", ctrl_o, 16'h0500);

    // R1: asynchronous reset mid path
    to_fetch();
    opcode_i = 6'b000000;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset uaddr", 16'(uaddr_o), 16'h0);
    chk("R1 async reset ctrl", ctrl_o, 16'h08A2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 restart after reset", 16'(uaddr_o), 16'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule